// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit maps a 16-bit logical address onto a physical address. It uses a per-process page table held in on-chip registers. The low bits of the address select a byte inside a 1024-byte page and pass through unchanged. The upper bits pick one table entry, which supplies the physical frame number. The frame number is placed above the offset to form the physical address.

Protection comes from three checks:
- A length register limits how many pages the process owns.
- Each entry carries a valid flag.
- Each entry carries a write-enable flag.

A request that fails any check produces a one-cycle fault pulse with a cause code and no address strobe. Software loads entries and the length register through a configuration write port. A write on that port applies to requests issued after it. A request in the same cycle as the write still sees the table as it was before the write.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset every entry is invalid, the length register is 0 and both output strobes are low, so any request faults with cause 0.
- R2: Address bits [9:0] are the in-page offset and appear unchanged in physical address bits [9:0]; bits [15:10] are the logical page number.
- R3: A permitted request yields physical address {frame, offset}, with frame taking bits [15:10]; page 0 mapped to frame 5 turns logical 0 into physical 5120 (0x1400).
- R4: resp_valid_o is high for exactly one cycle, in the cycle after req_valid_i was sampled high.
- R5: A page number greater than or equal to the length register produces a fault with cause 0 (out of range), including the page equal to the length.
- R6: A request to an in-range entry whose valid flag is clear produces a fault with cause 1 (invalid entry).
- R7: A write request (req_write_i=1) to a valid entry whose writable flag is clear produces a fault with cause 2 (write protect); a read of the same page translates normally.
- R8: When several checks fail, the cause follows the priority out-of-range, then invalid, then write protect; cause value 3 never appears.
- R9: fault_valid_o is a one-cycle pulse following a request and is never high together with resp_valid_o.
- R10: A configuration write of an entry (cfg_len_sel_i=0) affects requests issued in later cycles only; a request in the same cycle uses the previous entry contents.
- R11: A configuration write with cfg_len_sel_i=1 loads the length register from cfg_len_i, which may range from 0 to 64; a length of 64 puts every page in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 16 | Logical address |
| req_write_i | input | 1 | Request is a store (1) or a load (0) |
| resp_valid_o | output | 1 | Physical address strobe, one cycle |
| resp_paddr_o | output | 16 | Physical address |
| fault_valid_o | output | 1 | Fault pulse, one cycle |
| fault_cause_o | output | 2 | Fault cause: 0 range, 1 invalid, 2 write protect |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_len_sel_i | input | 1 | 1 writes the length register, 0 writes an entry |
| cfg_idx_i | input | 6 | Entry index for an entry write |
| cfg_frame_i | input | 6 | Frame number for an entry write |
| cfg_valid_i | input | 1 | Valid flag for an entry write |
| cfg_writable_i | input | 1 | Writable flag for an entry write |
| cfg_len_i | input | 7 | New length register value |

## Verification
The assertions check the following on every cycle:
- The address and fault strobes are never high together.
- Each strobe is preceded by a request.
- The offset passes through unchanged.
- Out-of-range and write-protected requests fault with the right cause.
- A permitted request carries the entry's frame.
- Configuration writes land in the table and in the length register.

Only the bench scenarios can show the rest:
- Address values for specific mappings, such as page 0 to frame 5.
- The cause priority when several checks fail at once.
- The boundary page equal to the length.
- That a request issued in the same cycle as an entry write still sees the old entry.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    FC_RANGE   = 2'd0,
    FC_INVALID = 2'd1,
    FC_WPROT   = 2'd2
  } fault_cause_e;
endpackage

// File: rtl/pxu_table.sv
module pxu_table #(
  parameter int PAGE_W  = 6,
  parameter int FRAME_W = 6,
  localparam int NPAGES = 1 << PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_len_sel_i,
  input  logic [PAGE_W-1:0]  cfg_idx_i,
  input  logic [FRAME_W-1:0] cfg_frame_i,
  input  logic               cfg_valid_i,
  input  logic               cfg_writable_i,
  input  logic [PAGE_W:0]    cfg_len_i,
  input  logic [PAGE_W-1:0]  rd_idx_i,
  output logic [FRAME_W-1:0] rd_frame_o,
  output logic               rd_valid_o,
  output logic               rd_writable_o,
  output logic [PAGE_W:0]    len_o
);
  logic [FRAME_W-1:0] frame_q [NPAGES];
  logic [NPAGES-1:0]  valid_q;
  logic [NPAGES-1:0]  wr_ok_q;
  logic [PAGE_W:0]    len_q;

  for (genvar g = 0; g < NPAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_q[g] <= '0;
        valid_q[g] <= 1'b0;
        wr_ok_q[g] <= 1'b0;
      end else if (cfg_we_i && !cfg_len_sel_i && cfg_idx_i == PAGE_W'(g)) begin
        frame_q[g] <= cfg_frame_i;
        valid_q[g] <= cfg_valid_i;
        wr_ok_q[g] <= cfg_writable_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        len_q <= '0;
    else if (cfg_we_i && cfg_len_sel_i) len_q <= cfg_len_i;
  end

  assign rd_frame_o    = frame_q[rd_idx_i];
  assign rd_valid_o    = valid_q[rd_idx_i];
  assign rd_writable_o = wr_ok_q[rd_idx_i];
  assign len_o         = len_q;

  p_entry_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_len_sel_i) |=>
      (frame_q[$past(cfg_idx_i)] == $past(cfg_frame_i) &&
       valid_q[$past(cfg_idx_i)] == $past(cfg_valid_i)));

  p_len_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_len_sel_i) |=> (len_o == $past(cfg_len_i)));
endmodule

// File: rtl/pxu_check.sv
module pxu_check
  import pxu_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic              write_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W:0]   len_i,
  input  logic              ent_valid_i,
  input  logic              ent_writable_i,
  output logic              fault_o,
  output fault_cause_e      cause_o
);
  logic out_of_range;
  assign out_of_range = ({1'b0, page_i} >= len_i);

  // priority: range, then invalid, then write protect
  always_comb begin
    fault_o = 1'b1;
    cause_o = FC_RANGE;
    if (out_of_range)                   cause_o = FC_RANGE;
    else if (!ent_valid_i)              cause_o = FC_INVALID;
    else if (write_i && !ent_writable_i) cause_o = FC_WPROT;
    else                                fault_o = 1'b0;
  end
endmodule

// File: rtl/pxu_resp.sv
module pxu_resp
  import pxu_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 6,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               fault_i,
  input  fault_cause_e       cause_i,
  output logic               resp_valid_o,
  output logic [PA_W-1:0]    resp_paddr_o,
  output logic               fault_valid_o,
  output logic [1:0]         fault_cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      fault_valid_o <= 1'b0;
      resp_paddr_o  <= '0;
      fault_cause_o <= '0;
    end else begin
      resp_valid_o  <= req_valid_i && !fault_i;
      fault_valid_o <= req_valid_i && fault_i;
      if (req_valid_i) begin
        resp_paddr_o  <= fault_i ? '0 : {frame_i, off_i};
        fault_cause_o <= fault_i ? cause_i : FC_RANGE;
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resp_valid_o && fault_valid_o));

  p_fault_after_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> $past(req_valid_i));

  p_strobe_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i));

  p_offset_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_paddr_o[OFF_W-1:0] == $past(off_i)));

  p_cause_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_o |-> (fault_cause_o != 2'd3));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 6,
  localparam int PAGE_W = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_addr_i,
  input  logic               req_write_i,
  output logic               resp_valid_o,
  output logic [PA_W-1:0]    resp_paddr_o,
  output logic               fault_valid_o,
  output logic [1:0]         fault_cause_o,
  input  logic               cfg_we_i,
  input  logic               cfg_len_sel_i,
  input  logic [PAGE_W-1:0]  cfg_idx_i,
  input  logic [FRAME_W-1:0] cfg_frame_i,
  input  logic               cfg_valid_i,
  input  logic               cfg_writable_i,
  input  logic [PAGE_W:0]    cfg_len_i
);
  logic [PAGE_W-1:0]  page;
  logic [OFF_W-1:0]   off;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_valid, ent_wr_ok, fault;
  logic [PAGE_W:0]    len;
  fault_cause_e       cause;

  assign page = req_addr_i[VA_W-1:OFF_W];
  assign off  = req_addr_i[OFF_W-1:0];

  pxu_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) i_table (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_len_sel_i, .cfg_idx_i, .cfg_frame_i,
    .cfg_valid_i, .cfg_writable_i, .cfg_len_i,
    .rd_idx_i(page), .rd_frame_o(ent_frame), .rd_valid_o(ent_valid),
    .rd_writable_o(ent_wr_ok), .len_o(len)
  );

  pxu_check #(.PAGE_W(PAGE_W)) i_check (
    .write_i(req_write_i), .page_i(page), .len_i(len),
    .ent_valid_i(ent_valid), .ent_writable_i(ent_wr_ok),
    .fault_o(fault), .cause_o(cause)
  );

  pxu_resp #(.OFF_W(OFF_W), .FRAME_W(FRAME_W)) i_resp (
    .clk_i, .rst_ni, .req_valid_i, .off_i(off), .frame_i(ent_frame),
    .fault_i(fault), .cause_i(cause),
    .resp_valid_o, .resp_paddr_o, .fault_valid_o, .fault_cause_o
  );

  p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ({1'b0, page} >= len)) |=>
      (fault_valid_o && fault_cause_o == FC_RANGE));

  p_wprot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && ({1'b0, page} < len) && ent_valid && !ent_wr_ok) |=>
      (fault_valid_o && fault_cause_o == FC_WPROT));

  p_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ({1'b0, page} < len) && ent_valid && (!req_write_i || ent_wr_ok)) |=>
      (resp_valid_o && resp_paddr_o[PA_W-1:OFF_W] == $past(ent_frame)));
endmodule

// File: tb/test_page_xlate_unit.sv
module test_page_xlate_unit;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        req_valid_i = 0;
  logic [15:0] req_addr_i = '0;
  logic        req_write_i = 0;
  logic        resp_valid_o;
  logic [15:0] resp_paddr_o;
  logic        fault_valid_o;
  logic [1:0]  fault_cause_o;
  logic        cfg_we_i = 0;
  logic        cfg_len_sel_i = 0;
  logic [5:0]  cfg_idx_i = '0;
  logic [5:0]  cfg_frame_i = '0;
  logic        cfg_valid_i = 0;
  logic        cfg_writable_i = 0;
  logic [6:0]  cfg_len_i = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  page_xlate_unit i_page_xlate_unit (.*);

  // {addr[35:20], write[19], is_fault[18], paddr[17:2], cause[1:0]}
  localparam int NV = 10;
  localparam logic [35:0] VECS [NV] = '{
    {16'h0000, 1'b0, 1'b0, 16'h1400, 2'd0},  // R3 page0->frame5
    {16'h0400, 1'b0, 1'b0, 16'h0400, 2'd0},  // R7 read of read-only ok
    {16'h0BB8, 1'b0, 1'b0, 16'h03B8, 2'd0},  // R2 logical 3000 -> 952
    {16'h0405, 1'b1, 1'b1, 16'h0000, 2'd2},  // R7 store to read-only
    {16'h0C00, 1'b0, 1'b1, 16'h0000, 2'd1},  // R6 invalid
    {16'h0C00, 1'b1, 1'b1, 16'h0000, 2'd1},  // R8 invalid beats wprot
    {16'h2000, 1'b0, 1'b1, 16'h0000, 2'd0},  // R5 page == length
    {16'h1FFF, 1'b1, 1'b0, 16'hFFFF, 2'd0},  // R3 top frame, top offset
    {16'hFFFF, 1'b0, 1'b1, 16'h0000, 2'd0},  // R5 far out of range
    {16'h0801, 1'b1, 1'b0, 16'h0001, 2'd0}   // R3 frame 0 store
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_entry(input logic [5:0] idx, input logic [5:0] fr, input logic v, input logic w);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_len_sel_i = 0; cfg_idx_i = idx; cfg_frame_i = fr;
    cfg_valid_i = v; cfg_writable_i = w;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic wr_len(input logic [6:0] l);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_len_sel_i = 1; cfg_len_i = l;
    @(negedge clk_i);
    cfg_we_i = 0; cfg_len_sel_i = 0;
  endtask

  // issue at a negedge; outputs are registered at the next posedge, sampled at the next negedge
  task automatic do_req(input logic [15:0] a, input logic w);
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a; req_write_i = w;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 resp_valid in reset", {31'd0, resp_valid_o}, 0);
    chk("R1 fault_valid in reset", {31'd0, fault_valid_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    do_req(16'h0000, 0);
    chk("R1 fault after reset", {31'd0, fault_valid_o}, 1);
    chk("R1 cause after reset", {30'd0, fault_cause_o}, 0);
    chk("R1 no strobe after reset", {31'd0, resp_valid_o}, 0);

    wr_entry(6'd0, 6'd5, 1, 1);
    wr_entry(6'd1, 6'd1, 1, 0);
    wr_entry(6'd2, 6'd0, 1, 1);
    wr_entry(6'd3, 6'd7, 0, 0);
    wr_entry(6'd7, 6'd63, 1, 1);
    wr_entry(6'd8, 6'd4, 0, 0);
    wr_len(7'd8);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VECS[i];
      do_req(v[35:20], v[19]);
      chk($sformatf("vec%0d R2 R3 R5 R6 R7 R8 fault", i), {31'd0, fault_valid_o}, {31'd0, v[18]});
      chk($sformatf("vec%0d R4 strobe", i), {31'd0, resp_valid_o}, {31'd0, ~v[18]});
      if (v[18]) chk($sformatf("vec%0d R8 cause", i), {30'd0, fault_cause_o}, {30'd0, v[1:0]});
      else       chk($sformatf("vec%0d R3 paddr", i), {16'd0, resp_paddr_o}, {16'd0, v[17:2]});
    end

    // R4 R9: one-cycle pulses
    do_req(16'h0000, 0);
    @(negedge clk_i);
    chk("R4 strobe drops", {31'd0, resp_valid_o}, 0);
    do_req(16'h0C00, 0);
    @(negedge clk_i);
    chk("R9 fault drops", {31'd0, fault_valid_o}, 0);

    // R10: same-cycle entry write does not affect the request
    @(negedge clk_i);
    cfg_we_i = 1; cfg_len_sel_i = 0; cfg_idx_i = 6'd4; cfg_frame_i = 6'd9;
    cfg_valid_i = 1; cfg_writable_i = 1;
    req_valid_i = 1; req_addr_i = 16'h1010; req_write_i = 0;
    @(negedge clk_i);
    cfg_we_i = 0; req_valid_i = 0;
    chk("R10 old entry used", {31'd0, fault_valid_o}, 1);
    chk("R10 old entry cause", {30'd0, fault_cause_o}, 1);
    do_req(16'h1010, 0);
    chk("R10 new entry used", {16'd0, resp_paddr_o}, 32'h2410);
    chk("R10 new entry strobe", {31'd0, resp_valid_o}, 1);

    // R11: full length puts page 63 in range
    wr_len(7'd64);
    do_req(16'hFFFF, 0);
    chk("R11 page63 invalid not range", {30'd0, fault_cause_o}, 1);
    wr_entry(6'd63, 6'd2, 1, 1);
    do_req(16'hFFFF, 1);
    chk("R11 page63 translated", {16'd0, resp_paddr_o}, 32'h0BFF);
    wr_len(7'd0);
    do_req(16'h0000, 0);
    chk("R5 length zero blocks page0", {30'd0, fault_cause_o}, 0);
    chk("R5 length zero fault", {31'd0, fault_valid_o}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule